// File: doc/BRIEF.md
# Supervisory Watchdog Timer with Initialization Lock

This block keeps watch over software that must prove it is alive. It starts counting by itself as soon as reset is released. Software must send a service strobe before the 16-bit up-counter wraps from 0xFFFF to 0x0000. A service loads the counter's upper byte from an 8-bit reload input and clears the lower byte, so the reload value sets how long the next interval is. The counter advances on a prescaled tick. A select input chooses one tick every 2 system clocks or one tick every 128.

Software may switch the watchdog off only during start-up. Once the end-of-initialization strobe has been seen, disable requests have no effect until the next reset. If the counter wraps, the block raises an internal reset request and pulls an active-low reset output low for 16 system clocks. It then returns to its post-reset state. A sticky flag records that the watchdog caused the reset, and only a power-on reset clears that flag.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` or `por` is high, and in the first cycle after both are released, the block is enabled and unlocked, `count` is 0x0000, `rst_n_out` is 1 and `rst_req` is 0.
- R2: With `slow_sel`=0, `count` advances by one every 2 clocks. With `slow_sel`=1, it advances by one every 128 clocks.
- R3: A `dis_stb` clears `wd_enabled` if the lock is not yet set. This includes a `dis_stb` in the same cycle as the first `eoi_stb`. Once `init_locked` is 1, `dis_stb` has no effect until the next reset, and a disabled watchdog stays disabled until the next reset.
- R4: A `svc_stb` sets `count` to {`reload_val`, 0x00} on the next edge and restarts the prescaler. If a service and an overflow fall in the same cycle, the service is taken and no overflow occurs.
- R5: The overflow happens (256 − reload) × 256 × ratio clocks after the service edge, or after the last reset edge with reload 0x00. The default is therefore 131072 clocks after reset.
- R6: On overflow, `rst_req`=1 and `rst_n_out`=0 for exactly 16 clocks. Then `count`=0, the block is enabled and unlocked, and counting restarts.
- R7: `wd_caused` goes to 1 on overflow. `rst` does not clear it, and only `por` clears it.
- R8: While disabled, `count` holds its value and no overflow occurs.
- R9: During the 16-clock reset hold, `eoi_stb`, `dis_stb` and `svc_stb` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| por | input | 1 | Synchronous power-on reset, active high; also clears the cause flag |
| eoi_stb | input | 1 | End-of-initialization strobe; sets the lock |
| dis_stb | input | 1 | Disable request strobe |
| svc_stb | input | 1 | Service strobe |
| reload_val | input | 8 | Upper-byte reload value used by a service |
| slow_sel | input | 1 | Prescaler select: 0 gives /2, 1 gives /128 |
| wd_enabled | output | 1 | Watchdog is running |
| init_locked | output | 1 | End-of-init seen; disabling is locked out |
| count | output | 16 | Current counter value |
| rst_req | output | 1 | Internal reset request, high during the hold |
| rst_n_out | output | 1 | Active-low reset for external logic |
| wd_caused | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
A wrong prescaler phase or a wrong reload shows up within one tick period as a `count` that is one step early or late. It also moves the `rst_n_out` fall by whole prescaler periods, so the bench samples the fall edge to the exact cycle. A wrong enable or lock state shows up on `wd_enabled` and `init_locked` in the cycle after the strobe, and as a counter that moves or freezes within two clocks. A wrong hold length shows up as `rst_n_out` rising one cycle early or late, 16 clocks after the fall.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int CNT_W    = 16;
  parameter int REL_W    = 8;
  parameter int DIV_FAST = 2;
  parameter int DIV_SLOW = 128;
  parameter int HOLD_CYC = 16;

  typedef enum logic [0:0] {WD_RUN = 1'b0, WD_HOLD = 1'b1} wd_phase_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clr_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PRE_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = slow_i ? LIM_SLOW : LIM_FAST;
  // ">=" keeps a ratio change mid-period from skipping a whole wrap
  assign tick_o = run_i && !clr_i && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr_i || !run_i || tick_o) pre_q <= '0;
    else                                  pre_q <= pre_q + 1'b1;
  end

  // R8: a stopped prescaler stays cleared
  assert_pre_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_i) |=> (pre_q == '0));
  // R2: two ticks are never adjacent
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16,
  parameter int REL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             svc_i,
  input  logic             tick_i,
  input  logic [REL_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int LOW_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cnt_q;

  // service beats a coincident wrap
  assign ovf_o = tick_i && !svc_i && !clr_i && (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)   cnt_q <= '0;
    else if (svc_i)     cnt_q <= {reload_i, {LOW_W{1'b0}}};
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  assert_svc_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (svc_i && !clr_i) |=> (cnt_q == {$past(reload_i), {LOW_W{1'b0}}}));
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !svc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int HOLD_N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic por_i,
  input  logic eoi_i,
  input  logic dis_i,
  input  logic ovf_i,
  output logic en_o,
  output logic lock_o,
  output logic hold_o,
  output logic req_o,
  output logic rst_n_o,
  output logic cause_o
);
  localparam int HC_W = (HOLD_N > 2) ? $clog2(HOLD_N) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HOLD_N - 1);

  wd_phase_e       phase_q;
  logic [HC_W-1:0] hcnt_q;
  logic            en_q, lock_q, req_q, rstn_q, cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= WD_RUN;
      hcnt_q  <= '0;
      en_q    <= 1'b1;
      lock_q  <= 1'b0;
      req_q   <= 1'b0;
      rstn_q  <= 1'b1;
    end else if (phase_q == WD_HOLD) begin
      en_q   <= 1'b1;
      lock_q <= 1'b0;
      if (hcnt_q == HC_LAST) begin
        phase_q <= WD_RUN;
        hcnt_q  <= '0;
        req_q   <= 1'b0;
        rstn_q  <= 1'b1;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end else if (ovf_i) begin
      phase_q <= WD_HOLD;
      hcnt_q  <= '0;
      req_q   <= 1'b1;
      rstn_q  <= 1'b0;
      en_q    <= 1'b1;
      lock_q  <= 1'b0;
    end else begin
      if (dis_i && !lock_q) en_q <= 1'b0;
      if (eoi_i)            lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por_i)                            cause_q <= 1'b0;
    else if (ovf_i && phase_q == WD_RUN)  cause_q <= 1'b1;
  end

  assign en_o    = en_q;
  assign lock_o  = lock_q;
  assign hold_o  = (phase_q == WD_HOLD);
  assign req_o   = req_q;
  assign rst_n_o = rstn_q;
  assign cause_o = cause_q;

  assert_lock_keeps_en_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_q && en_q) |=> en_q);
  assert_hold_stays_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!rstn_q && hcnt_q != HC_LAST) |=> !rstn_q);
  assert_req_matches_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (req_q == !rstn_q));
  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (por_i)
    cause_q |=> cause_q);
  assert_hold_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == WD_HOLD) |=> (!lock_q && en_q));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int RW  = REL_W,
  parameter int DVF = DIV_FAST,
  parameter int DVS = DIV_SLOW,
  parameter int HLD = HOLD_CYC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por,
  input  logic          eoi_stb,
  input  logic          dis_stb,
  input  logic          svc_stb,
  input  logic [RW-1:0] reload_val,
  input  logic          slow_sel,
  output logic          wd_enabled,
  output logic          init_locked,
  output logic [CW-1:0] count,
  output logic          rst_req,
  output logic          rst_n_out,
  output logic          wd_caused
);
  logic sys_rst, en, lock, hold, tick, ovf, svc_run;

  assign sys_rst = rst | por;
  assign svc_run = svc_stb & ~hold;

  wdog_prescaler #(.DIV_FAST(DVF), .DIV_SLOW(DVS)) u_pre (
    .clk(clk), .rst(sys_rst), .run_i(en & ~hold), .clr_i(hold | svc_run),
    .slow_i(slow_sel), .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CW), .REL_W(RW)) u_cnt (
    .clk(clk), .rst(sys_rst), .clr_i(hold), .svc_i(svc_run), .tick_i(tick),
    .reload_i(reload_val), .cnt_o(count), .ovf_o(ovf)
  );

  wdog_ctrl #(.HOLD_N(HLD)) u_ctl (
    .clk(clk), .rst(sys_rst), .por_i(por), .eoi_i(eoi_stb & ~hold),
    .dis_i(dis_stb & ~hold), .ovf_i(ovf), .en_o(en), .lock_o(lock),
    .hold_o(hold), .req_o(rst_req), .rst_n_o(rst_n_out), .cause_o(wd_caused)
  );

  assign wd_enabled  = en;
  assign init_locked = lock;

  assert_no_wrap_disabled_R8: assert property (@(posedge clk) disable iff (sys_rst)
    (!en) |=> rst_n_out);
endmodule

// File: tb/wdog_supervisor_tb_top.sv
module wdog_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1, por = 1'b1;
  logic        eoi_stb = 1'b0, dis_stb = 1'b0, svc_stb = 1'b0, slow_sel = 1'b0;
  logic [7:0]  reload_val = 8'h00;
  logic        wd_enabled, init_locked, rst_req, rst_n_out, wd_caused;
  logic [15:0] count;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_supervisor dut_i (
    .clk(clk), .rst(rst), .por(por), .eoi_stb(eoi_stb), .dis_stb(dis_stb),
    .svc_stb(svc_stb), .reload_val(reload_val), .slow_sel(slow_sel),
    .wd_enabled(wd_enabled), .init_locked(init_locked), .count(count),
    .rst_req(rst_req), .rst_n_out(rst_n_out), .wd_caused(wd_caused)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sys_reset(input bit with_por);
    rst = 1'b1; por = with_por;
    step(2);
    rst = 1'b0; por = 1'b0;
  endtask

  task automatic pulse_svc(input logic [7:0] rel);
    reload_val = rel; svc_stb = 1'b1;
    step(1);
    svc_stb = 1'b0;
  endtask

  task automatic t_reset_state;
    sys_reset(1);
    chk("R1 enabled", wd_enabled, 1);
    chk("R1 unlocked", init_locked, 0);
    chk("R1 count", count, 0);
    chk("R1 rst_n_out", rst_n_out, 1);
    chk("R1 rst_req", rst_req, 0);
    chk("R7 cause after por", wd_caused, 0);
  endtask

  task automatic t_default_timeout;
    sys_reset(0);
    step(10);
    chk("R2 fast rate", count, 5);
    step(131061);
    chk("R5 before default wrap", rst_n_out, 1);
    step(1);
    chk("R5 default wrap", rst_n_out, 0);
  endtask

  task automatic t_slow_rate;
    slow_sel = 1'b1;
    sys_reset(0);
    pulse_svc(8'h12);
    chk("R4 reload", count, 16'h1200);
    step(127);
    chk("R2 slow hold", count, 16'h1200);
    step(1);
    chk("R2 slow tick", count, 16'h1201);
    slow_sel = 1'b0;
  endtask

  task automatic t_overflow_hold;
    sys_reset(0);
    pulse_svc(8'hFF);
    step(511);
    chk("R5 before short wrap", rst_n_out, 1);
    step(1);
    chk("R6 rst_n low", rst_n_out, 0);
    chk("R6 req high", rst_req, 1);
    chk("R7 cause set", wd_caused, 1);
    eoi_stb = 1'b1; dis_stb = 1'b1; reload_val = 8'h40; svc_stb = 1'b1;
    step(3);
    eoi_stb = 1'b0; dis_stb = 1'b0; svc_stb = 1'b0;
    step(12);
    chk("R6 still low at 16th", rst_n_out, 0);
    chk("R9 svc ignored", count, 0);
    step(1);
    chk("R6 released", rst_n_out, 1);
    chk("R6 req released", rst_req, 0);
    chk("R9 lock ignored", init_locked, 0);
    chk("R9 disable ignored", wd_enabled, 1);
    step(2);
    chk("R6 counting restarts", count, 1);
  endtask

  task automatic t_cause_sticky;
    sys_reset(0);
    chk("R7 survives rst", wd_caused, 1);
    sys_reset(1);
    chk("R7 por clears", wd_caused, 0);
  endtask

  task automatic t_service_wins;
    sys_reset(0);
    pulse_svc(8'hFF);
    step(511);
    reload_val = 8'hF0; svc_stb = 1'b1;
    step(1);
    svc_stb = 1'b0;
    chk("R4 service beats wrap", rst_n_out, 1);
    chk("R4 reload on tie", count, 16'hF000);
    chk("R7 no cause on tie", wd_caused, 0);
    step(8191);
    chk("R5 F0 before wrap", rst_n_out, 1);
    step(1);
    chk("R5 F0 wrap", rst_n_out, 0);
    step(20);
  endtask

  task automatic t_disable;
    sys_reset(1);
    pulse_svc(8'hFF);
    dis_stb = 1'b1;
    step(1);
    dis_stb = 1'b0;
    chk("R3 disable before eoi", wd_enabled, 0);
    begin
      logic [15:0] snap = count;
      step(700);
      chk("R8 count holds", count, snap);
      chk("R8 no wrap", rst_n_out, 1);
    end
    eoi_stb = 1'b1;
    step(1);
    eoi_stb = 1'b0;
    chk("R3 stays disabled", wd_enabled, 0);
    sys_reset(0);
    eoi_stb = 1'b1;
    step(1);
    eoi_stb = 1'b0;
    chk("R3 locked", init_locked, 1);
    dis_stb = 1'b1;
    step(1);
    dis_stb = 1'b0;
    chk("R3 disable ignored", wd_enabled, 1);
    begin
      logic [15:0] snap = count;
      step(4);
      chk("R3 still counting", count, snap + 16'd2);
    end
    sys_reset(0);
    eoi_stb = 1'b1; dis_stb = 1'b1;
    step(1);
    eoi_stb = 1'b0; dis_stb = 1'b0;
    chk("R3 same-cycle disable", wd_enabled, 0);
    chk("R3 same-cycle lock", init_locked, 1);
  endtask

  initial begin
    step(1);
    t_reset_state();
    t_default_timeout();
    t_slow_rate();
    t_overflow_hold();
    t_cause_sticky();
    t_service_wins();
    t_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule